// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block takes the level-sensitive interrupt pins of the devices on a PCI bus and routes them to the request inputs of a legacy interrupt controller. Each device raises or drops one of its four pins, INTA to INTD, by presenting a slot number, a pin index and a level on a one-cycle event strobe. A fixed rotation by slot folds every device pin onto one of four shared interrupt lines. Four byte-wide route registers then steer each shared line onto one of sixteen controller inputs, or onto none.

The router stores every device pin level, so the current level of each shared line is always known inside the block. A 64-bit level map has one bit for each pair of controller input and shared line. Each controller request is the OR of the four map bits that belong to that input, so several shared lines can drive the same input. A pin event updates a single map bit. A write to the route registers clears the map and rebuilds it from the stored levels, one shared line per cycle. The request outputs hold their previous values until the rebuild completes.

Top module: `pirq_router`

## Requirements
- R1: A device pin with index i (INTA=0 … INTD=3) in slot s drives shared line (i + s − 1) mod 4, so slot 0 INTA maps to line 3 and slot 2 INTD maps to line 0.
- R2: Each shared line is high while at least one stored device pin that maps onto it is high. It drops only when all of those pins are low.
- R3: The route registers form the 32-bit word at dword address 0x18 (byte address 0x60). Byte lane k (bits 8k+7:8k) holds the route for shared line k. A write changes only the lanes whose byte enable is set. Writes to any other address leave routing and outputs unchanged.
- R4: A route value of 16 or more leaves its shared line unrouted, and that line then affects no output.
- R5: picReq[n] is high when, and only when, some shared line whose route equals n is high.
- R6: After reset every route register reads 0x80 (unrouted), all stored levels are low and picReq is zero.
- R7: When the block is idle, a pin event sampled at clock edge E shows on picReq right after edge E+2.
- R8: A route write sampled at edge T clears the level map and rebuilds it over edges T+1 to T+4. picReq keeps its prior value through edge T+4 and shows the new routing right after edge T+5.
- R9: A pin event that arrives during a rebuild is kept in the level store and starts another rebuild pass. Once the input is quiet, picReq matches R5.
- R10: A route write that arrives during a rebuild restarts the rebuild from shared line 0, and the restarted pass keeps the same T+5 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinValid | input | 1 | One-cycle strobe: a device pin level update is present |
| pinSlot | input | 5 | Slot number of the device (device/function number shifted right by 3) |
| pinIdx | input | 2 | Interrupt pin index, 0=INTA … 3=INTD |
| pinLevel | input | 1 | New level of that pin |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgDwAddr | input | 6 | Dword address of the configuration write (byte address bits 7:2) |
| cfgData | input | 32 | Write data, byte lane k in bits 8k+7:8k |
| cfgBe | input | 4 | Byte enables for the four lanes |
| picReq | output | 16 | Request levels to the interrupt controller inputs |

## Verification
The assertions assume that pin events and route writes are strobes sampled once per clock. They also assume that pinSlot always names an existing slot and that configuration writes never overlap reset. The restart and rerun checks further assume that events arriving during a rebuild are eventually followed by a quiet interval. The stimulus meets these assumptions by construction. Every strobe is driven for exactly one cycle at the falling edge, slots are drawn from the full 5-bit range, and every final comparison waits a settle interval long enough for any rebuild to finish. Random bursts with short gaps deliberately put events and writes inside a rebuild before the bench lets the router go quiet.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

  localparam int PIRQ_NUM = 4;
  localparam int PIRQ_W   = 2;
  localparam int PIN_NUM  = 4;
  localparam int PIN_W    = 2;
  localparam int ROUTE_W  = 8;

  typedef struct packed {
    logic              clearMap;
    logic              scanEn;
    logic [PIRQ_W-1:0] scanIdx;
    logic              publish;
  } rtStrobe_t;

endpackage

// File: rtl/pirq_router_ctrl.sv
module pirq_router_ctrl
  import pirq_router_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       routeHit,
  input  logic       pinValid,
  output rtStrobe_t  strb
);

  logic              scanning;
  logic [PIRQ_W-1:0] idx;
  logic              rerun;
  logic              lastIdx;
  logic              restart;

  assign lastIdx = scanning && (idx == PIRQ_W'(PIRQ_NUM - 1));
  assign restart = routeHit || (lastIdx && (rerun || pinValid));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning <= 1'b0;
      idx      <= '0;
      rerun    <= 1'b0;
    end else if (restart) begin
      scanning <= 1'b1;
      idx      <= '0;
      rerun    <= 1'b0;
    end else if (scanning) begin
      idx <= idx + 1'b1;
      if (lastIdx) scanning <= 1'b0;
      if (pinValid) rerun <= 1'b1;
    end
  end

  always_comb begin
    strb.clearMap = restart;
    strb.scanEn   = scanning;
    strb.scanIdx  = idx;
    strb.publish  = !scanning;
  end

  // R10: a route write always starts a fresh pass at line 0
  a_r10_restart: assert property (@(posedge clk) disable iff (!rstN)
    routeHit |=> (scanning && idx == '0));

  // R8: an undisturbed pass advances one line per cycle
  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    (scanning && !lastIdx && !routeHit) |=> (scanning && idx == PIRQ_W'($past(idx) + 1'b1)));

  // R9: activity during a pass forces another pass
  a_r9_rerun: assert property (@(posedge clk) disable iff (!rstN)
    (lastIdx && pinValid) |=> (scanning && idx == '0));

endmodule

// File: rtl/pirq_router_dp.sv
module pirq_router_dp
  import pirq_router_pkg::*;
#(
  parameter int SLOT_NUM   = 32,
  parameter int PIC_NUM    = 16,
  parameter logic [7:0] ROUTE_ADDR = 8'h60
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pinValid,
  input  logic [$clog2(SLOT_NUM)-1:0] pinSlot,
  input  logic [PIN_W-1:0]            pinIdx,
  input  logic                        pinLevel,
  input  logic                        cfgWrEn,
  input  logic [5:0]                  cfgDwAddr,
  input  logic [31:0]                 cfgData,
  input  logic [3:0]                  cfgBe,
  input  rtStrobe_t                   strb,
  output logic                        routeHit,
  output logic [PIC_NUM-1:0]          picReq
);

  localparam int SLOT_W = $clog2(SLOT_NUM);
  localparam int PIC_W  = $clog2(PIC_NUM);
  localparam int MAP_W  = PIC_NUM * PIRQ_NUM;

  logic [PIRQ_NUM-1:0][ROUTE_W-1:0] routeReg;
  logic [SLOT_NUM-1:0][PIN_NUM-1:0] pinStore;
  logic [PIRQ_NUM-1:0]              pirqLevel;
  logic [MAP_W-1:0]                 bitMap;
  logic [PIC_NUM-1:0]               picOr;
  logic                             evtPend;
  logic [PIRQ_W-1:0]                evtPirq;
  logic [SLOT_W:0]                  swzSum;
  logic [PIRQ_W-1:0]                selPirq;
  logic [ROUTE_W-1:0]               selRoute;
  logic                             selRouted;
  logic                             mapWr;
  logic [PIC_W+PIRQ_W-1:0]          mapBit;

  assign routeHit = cfgWrEn && (cfgDwAddr == ROUTE_ADDR[7:2]) && (|cfgBe);

  // route registers, one byte lane each
  for (genvar k = 0; k < PIRQ_NUM; k++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       routeReg[k] <= 8'h80;
      else if (routeHit && cfgBe[k])   routeReg[k] <= cfgData[8*k +: 8];
    end
  end

  // pin level store
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pinStore <= '0;
    else if (pinValid)  pinStore[pinSlot][pinIdx] <= pinLevel;
  end

  // shared line level: OR of every stored pin rotated onto it
  always_comb begin
    pirqLevel = '0;
    for (int s = 0; s < SLOT_NUM; s++) begin
      for (int i = 0; i < PIN_NUM; i++) begin
        pirqLevel[PIRQ_W'((s + i + PIRQ_NUM - 1) % PIRQ_NUM)] =
          pirqLevel[PIRQ_W'((s + i + PIRQ_NUM - 1) % PIRQ_NUM)] | pinStore[s][i];
      end
    end
  end

  // slot rotation of the incoming event (adding PIRQ_NUM-1 subtracts one)
  assign swzSum = {1'b0, pinSlot} + (SLOT_W+1)'(pinIdx) + (SLOT_W+1)'(PIRQ_NUM - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPend <= 1'b0;
      evtPirq <= '0;
    end else begin
      evtPend <= pinValid && strb.publish && !routeHit;
      evtPirq <= swzSum[PIRQ_W-1:0];
    end
  end

  // single write port into the level map
  assign selPirq   = strb.scanEn ? strb.scanIdx : evtPirq;
  assign selRoute  = routeReg[selPirq];
  assign selRouted = selRoute < ROUTE_W'(PIC_NUM);
  assign mapWr     = !strb.clearMap && (strb.scanEn || evtPend) && selRouted;
  assign mapBit    = {selRoute[PIC_W-1:0], selPirq};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitMap <= '0;
    else if (strb.clearMap) bitMap <= '0;
    else if (mapWr)         bitMap[mapBit] <= pirqLevel[selPirq];
  end

  for (genvar g = 0; g < PIC_NUM; g++) begin : g_pic
    assign picOr[g] = |bitMap[g*PIRQ_NUM +: PIRQ_NUM];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             picReq <= '0;
    else if (strb.publish) picReq <= picOr;
  end

  // R8: outputs frozen while a pass is in flight
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.publish |=> $stable(picReq));

  // R4: scanning an unrouted line leaves the map alone
  a_r4_unrouted: assert property (@(posedge clk) disable iff (!rstN)
    (strb.scanEn && !strb.clearMap && routeReg[strb.scanIdx] >= ROUTE_W'(PIC_NUM))
      |=> $stable(bitMap));

  // R3: writes elsewhere do not touch routing
  a_r3_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !routeHit) |=> $stable(routeReg));

  // R5: an empty map publishes no request
  a_r5_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strb.publish && bitMap == '0) |=> (picReq == '0));

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int SLOT_NUM = 32,
  parameter int PIC_NUM  = 16,
  parameter logic [7:0] ROUTE_ADDR = 8'h60
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pinValid,
  input  logic [$clog2(SLOT_NUM)-1:0] pinSlot,
  input  logic [1:0]                  pinIdx,
  input  logic                        pinLevel,
  input  logic                        cfgWrEn,
  input  logic [5:0]                  cfgDwAddr,
  input  logic [31:0]                 cfgData,
  input  logic [3:0]                  cfgBe,
  output logic [PIC_NUM-1:0]          picReq
);

  rtStrobe_t strb;
  logic      routeHit;

  pirq_router_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .routeHit (routeHit),
    .pinValid (pinValid),
    .strb     (strb)
  );

  pirq_router_dp #(
    .SLOT_NUM   (SLOT_NUM),
    .PIC_NUM    (PIC_NUM),
    .ROUTE_ADDR (ROUTE_ADDR)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .pinValid  (pinValid),
    .pinSlot   (pinSlot),
    .pinIdx    (pinIdx),
    .pinLevel  (pinLevel),
    .cfgWrEn   (cfgWrEn),
    .cfgDwAddr (cfgDwAddr),
    .cfgData   (cfgData),
    .cfgBe     (cfgBe),
    .strb      (strb),
    .routeHit  (routeHit),
    .picReq    (picReq)
  );

endmodule

// File: tb/pirq_router_tb_top.sv
module pirq_router_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinValid = 1'b0;
  logic [4:0]  pinSlot = '0;
  logic [1:0]  pinIdx = '0;
  logic        pinLevel = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [31:0] cfgData = '0;
  logic [3:0]  cfgBe = '0;
  logic [15:0] picReq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [3:0] mStore [32];
  logic [7:0] mRoute [4];

  always #5 clk = ~clk;

  pirq_router dut_i (
    .clk(clk), .rstN(rstN), .pinValid(pinValid), .pinSlot(pinSlot),
    .pinIdx(pinIdx), .pinLevel(pinLevel), .cfgWrEn(cfgWrEn),
    .cfgDwAddr(cfgDwAddr), .cfgData(cfgData), .cfgBe(cfgBe), .picReq(picReq)
  );

  function automatic logic [15:0] expPic();
    logic [15:0] e = '0;
    for (int p = 0; p < 4; p++) begin
      logic lvl = 1'b0;
      for (int s = 0; s < 32; s++)
        for (int i = 0; i < 4; i++)
          if (((i + s + 3) % 4) == p) lvl = lvl | mStore[s][i];
      if (mRoute[p] < 8'd16 && lvl) e[mRoute[p][3:0]] = 1'b1;
    end
    return e;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: picReq actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pinEvent(input int slot, input int pin, input logic lvl);
    @(negedge clk);
    pinValid = 1'b1; pinSlot = 5'(slot); pinIdx = 2'(pin); pinLevel = lvl;
    mStore[slot][pin] = lvl;
    @(negedge clk);
    pinValid = 1'b0;
  endtask

  task automatic cfgWrite(input logic [5:0] dw, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgDwAddr = dw; cfgData = d; cfgBe = be;
    if (dw == 6'h18 && be != 4'h0)
      for (int k = 0; k < 4; k++) if (be[k]) mRoute[k] = d[8*k +: 8];
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] saved;
    void'($urandom(32'h5eed));
    for (int s = 0; s < 32; s++) mStore[s] = '0;
    for (int k = 0; k < 4; k++) mRoute[k] = 8'h80;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 reset outputs", picReq, 16'h0);

    // R6/R4: default routes are unrouted, so an asserted pin does nothing
    pinEvent(1, 0, 1'b1);
    settle(6);
    check("R6 reset routes unrouted", picReq, 16'h0);

    // R8: route line0 -> 3, outputs show after T+5
    cfgWrite(6'h18, 32'h8080_8003, 4'h1);
    settle(4);
    check("R8 hold through T+4", picReq, 16'h0);
    settle(1);
    check("R8 new routing after T+5", picReq, 16'h0008);

    // R8: move line0 -> 7, hold old then switch
    saved = picReq;
    cfgWrite(6'h18, 32'h0000_0007, 4'h1);
    settle(4);
    check("R8 hold prior value", picReq, saved);
    settle(1);
    check("R8 rerouted", picReq, 16'h0080);

    // R7: latency of an idle pin event (slot1 pin0 low -> line0 low)
    @(negedge clk);
    pinValid = 1'b1; pinSlot = 5'd1; pinIdx = 2'd0; pinLevel = 1'b0;
    mStore[1][0] = 1'b0;
    @(negedge clk);
    pinValid = 1'b0;
    @(negedge clk);
    check("R7 unchanged after E+1", picReq, 16'h0080);
    @(negedge clk);
    check("R7 updated after E+2", picReq, 16'h0000);

    // R1: route all lines distinctly, then probe the rotation
    cfgWrite(6'h18, 32'h0C0B_0A09, 4'hF);   // line0->9, 1->10, 2->11, 3->12
    settle(6);
    pinEvent(0, 0, 1'b1);                    // slot0 INTA -> line3
    settle(3);
    check("R1 slot0 INTA to line3", picReq, 16'h1000);
    pinEvent(2, 3, 1'b1);                    // slot2 INTD -> line0
    settle(3);
    check("R1 slot2 INTD to line0", picReq, 16'h1200);
    pinEvent(0, 0, 1'b0);
    pinEvent(2, 3, 1'b0);
    settle(3);
    check("R1 all low", picReq, 16'h0000);

    // R2: two pins on line1 (slot1 INTB, slot2 INTA)
    pinEvent(1, 1, 1'b1);
    pinEvent(2, 0, 1'b1);
    settle(3);
    check("R2 two pins high", picReq, 16'h0400);
    pinEvent(1, 1, 1'b0);
    settle(3);
    check("R2 one pin still high", picReq, 16'h0400);
    pinEvent(2, 0, 1'b0);
    settle(3);
    check("R2 both low", picReq, 16'h0000);

    // R5: lines 0 and 2 share input 5
    cfgWrite(6'h18, 32'h8005_8005, 4'hF);
    settle(6);
    pinEvent(1, 0, 1'b1);   // line0
    pinEvent(1, 2, 1'b1);   // line2
    settle(3);
    check("R5 shared input", picReq, 16'h0020);
    pinEvent(1, 0, 1'b0);
    settle(3);
    check("R5 shared input OR", picReq, 16'h0020);

    // R4: unrouting line2 via partial enable (route 0x10)
    cfgWrite(6'h18, 32'h0010_0000, 4'h4);
    settle(6);
    check("R4 value 16 unroutes", picReq, 16'h0000);

    // R3: writes elsewhere are ignored
    cfgWrite(6'h19, 32'h0303_0303, 4'hF);
    cfgWrite(6'h18, 32'h0303_0303, 4'h0);
    settle(6);
    check("R3 other address ignored", picReq, 16'h0000);
    pinEvent(1, 0, 1'b1);   // line0 still routes to 5
    settle(3);
    check("R3 route kept", picReq, 16'h0020);

    // R9: events inside a rebuild
    cfgWrite(6'h18, 32'h0E0D_0201, 4'hF);
    pinEvent(3, 0, 1'b1);
    pinEvent(4, 3, 1'b1);
    settle(14);
    check("R9 events during rebuild", picReq, expPic());

    // R10: second write mid-rebuild restarts the pass
    saved = picReq;
    cfgWrite(6'h18, 32'h0F00_0604, 4'hF);
    @(negedge clk);
    cfgWrite(6'h18, 32'h0708_0900, 4'hF);
    settle(4);
    check("R10 hold after restart", picReq, saved);
    settle(1);
    check("R10 restarted routing", picReq, expPic());

    // random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom_range(0, 4) == 0) begin
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
          int r = $urandom_range(0, 9);
          d[8*k +: 8] = (r < 8) ? 8'($urandom_range(0, 15)) : ((r == 8) ? 8'h10 : 8'hFF);
        end
        cfgWrite(($urandom_range(0, 5) == 0) ? 6'h1A : 6'h18, d, 4'($urandom_range(0, 15)));
      end else begin
        pinEvent($urandom_range(0, 31), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
      end
      settle($urandom_range(0, 3));
      if (it % 8 == 7) begin
        settle(14);
        check("R5/R9 random", picReq, expPic());
      end
    end
    settle(14);
    check("R5 final", picReq, expPic());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule